// File: doc/BRIEF.md
# Single-Bus Accumulator Add Sequencer

This block is a small datapath in which every register talks to every other one over a single shared internal bus. Each register has an output gate and a load gate. An output gate puts the register onto the bus, and a load gate captures the bus or a dedicated input on the next clock edge. At most one output gate is open in any cycle. The bus is built as an AND-OR network, so it behaves like a tri-state bus without real tri-state drivers.

A step sequencer opens the gates in the right order to perform one operation: add the memory word at the instruction's address field into the accumulator. The adder has no storage of its own. One operand comes from a temporary register `Y`, the other comes straight from the bus, and the sum is held in a second temporary register `Z` until a later step moves it to the accumulator. The operation therefore takes five steps:

1. The address field moves to the memory address register.
2. The memory word is read into the buffer register.
3. The buffer moves to `Y`.
4. The accumulator drives the bus while `Z` captures the sum.
5. `Z` moves to the accumulator.

A `done` pulse follows, and the sequencer then returns to idle.

A host starts an operation by presenting the instruction word together with `start` while the sequencer is idle. Memory is outside the block. It must return `mem_rdata` for `mem_addr` in the same cycle that `mem_rd` is high.

Top module: `sbus_acc_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done`, `busy`, `mem_rd` and `bus_conflict` are 0, and `ac_out` and `pc_out` are 0.
- R2: A `start` sampled high at a rising edge while idle captures `instr_in` and makes `busy` high for exactly the next six cycles (five steps plus the done cycle). After that the block is idle again.
- R3: `mem_rd` is high for exactly one cycle per operation, the second cycle after the accepting edge. In that cycle `mem_addr` equals `instr_in[11:0]` of the accepted instruction.
- R4: `done` is high for exactly one cycle, the sixth cycle after the accepting edge. In that cycle `ac_out` equals the previous accumulator value plus the memory word read in R3, and `done` is low in the following cycle.
- R5: `start` while busy has no effect. It changes neither the timing of the running operation nor its result, and it does not replace the captured instruction.
- R6: No two output gates are ever open in the same cycle, so `bus_conflict` stays 0. In the accumulate step (step 4) the only register that loads is `Z`.
- R7: Only bits [11:0] of the instruction form the address. Bits [15:12] do not affect `mem_addr` or the result.
- R8: The addition wraps modulo 2^16, and no carry is kept anywhere.
- R9: No step of this operation gates the program counter, so `pc_out` keeps its reset value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an add operation when idle |
| instr_in | input | 16 | Instruction word, address field in bits [11:0] |
| mem_rdata | input | 16 | Read data, valid in the cycle `mem_rd` is high |
| mem_rd | output | 1 | Memory read strobe (step 2) |
| mem_addr | output | 12 | Memory address, driven from the address register |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High from step 1 through the done cycle |
| ac_out | output | 16 | Accumulator contents |
| pc_out | output | 12 | Program counter contents |
| bus_conflict | output | 1 | Registered flag: more than one output gate was open |

## Verification
The bench builds the block at its defaults, a 16-bit datapath and a 12-bit address field. With these widths, random instruction words reach every address bit and every opcode bit. Random memory words make the 16-bit accumulator wrap often, so R8 is exercised without special setup. Directed cases cover address 0, address 0xFFF, words with all upper instruction bits set, and a second `start` issued mid-operation. The step-by-step check of `mem_rd`, `busy` and `done` pins the exact cycle of every step.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4,
    ST_T5   = 3'd5,
    ST_DONE = 3'd6
  } step_e;

  // bus sources (output gates)
  localparam int SRC_IR  = 0;
  localparam int SRC_MBR = 1;
  localparam int SRC_AC  = 2;
  localparam int SRC_Z   = 3;
  localparam int SRC_PC  = 4;
  localparam int NSRC    = 5;

  // load gates
  localparam int LD_MAR = 0;
  localparam int LD_MBR = 1;
  localparam int LD_Y   = 2;
  localparam int LD_Z   = 3;
  localparam int LD_AC  = 4;
  localparam int LD_IR  = 5;
  localparam int LD_PC  = 6;
  localparam int NLD    = 7;

endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/sbus_bus.sv
module sbus_bus #(
  parameter int W = 16,
  parameter int N = 5
) (
  input  logic [N-1:0]        en,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        bus,
  output logic                multi
);
  logic [N-1:0][W-1:0] gated;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_gate
      assign gated[gi] = src[gi] & {W{en[gi]}};
    end
  endgenerate

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | gated[i];
  end

  assign multi = ($countones(en) > 1);
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] sum
);
  assign sum = opa + opb;
endmodule

// File: rtl/sbus_step_ctrl.sv
module sbus_step_ctrl
  import sbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output step_e           step,
  output logic [NSRC-1:0] drv_en,
  output logic [NLD-1:0]  ld_en,
  output logic            mem_rd,
  output logic            done,
  output logic            busy
);
  step_e step_q;

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else begin
      case (step_q)
        ST_IDLE: if (start) step_q <= ST_T1;
        ST_T1:   step_q <= ST_T2;
        ST_T2:   step_q <= ST_T3;
        ST_T3:   step_q <= ST_T4;
        ST_T4:   step_q <= ST_T5;
        ST_T5:   step_q <= ST_DONE;
        default: step_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    drv_en = '0;
    ld_en  = '0;
    case (step_q)
      ST_IDLE: ld_en[LD_IR] = start;
      ST_T1: begin drv_en[SRC_IR]  = 1'b1; ld_en[LD_MAR] = 1'b1; end
      ST_T2: ld_en[LD_MBR] = 1'b1;
      ST_T3: begin drv_en[SRC_MBR] = 1'b1; ld_en[LD_Y]  = 1'b1; end
      ST_T4: begin drv_en[SRC_AC]  = 1'b1; ld_en[LD_Z]  = 1'b1; end
      ST_T5: begin drv_en[SRC_Z]   = 1'b1; ld_en[LD_AC] = 1'b1; end
      default: ;
    endcase
  end

  assign step   = step_q;
  assign mem_rd = (step_q == ST_T2);
  assign done   = (step_q == ST_DONE);
  assign busy   = (step_q != ST_IDLE);

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_en)); // R6
  AST_T4_ONLY_Z: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_T4) |-> (ld_en == (NLD'(1) << LD_Z))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R5
endmodule

// File: rtl/sbus_acc_ctrl.sv
module sbus_acc_ctrl
  import sbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] instr_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] ac_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              bus_conflict
);
  step_e                   step;
  logic [NSRC-1:0]         drv_en;
  logic [NLD-1:0]          ld_en;
  logic [NSRC-1:0][DATA_W-1:0] src;
  logic [DATA_W-1:0]       bus;
  logic                    multi;
  logic [DATA_W-1:0]       ir_q, mbr_q, ac_q, y_q, z_q, alu_sum, pc_ext;
  logic [ADDR_W-1:0]       mar_q, pc_q;
  logic                    conflict_q;

  sbus_step_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .step(step),
    .drv_en(drv_en), .ld_en(ld_en), .mem_rd(mem_rd),
    .done(done), .busy(busy)
  );

  sbus_reg #(.W(DATA_W)) u_ir  (.clk(clk), .rst(rst), .ld(ld_en[LD_IR]),
    .d(instr_in), .q(ir_q));
  sbus_reg #(.W(ADDR_W)) u_mar (.clk(clk), .rst(rst), .ld(ld_en[LD_MAR]),
    .d(bus[ADDR_W-1:0]), .q(mar_q));
  sbus_reg #(.W(DATA_W)) u_mbr (.clk(clk), .rst(rst), .ld(ld_en[LD_MBR]),
    .d(mem_rdata), .q(mbr_q));
  sbus_reg #(.W(DATA_W)) u_y   (.clk(clk), .rst(rst), .ld(ld_en[LD_Y]),
    .d(bus), .q(y_q));
  sbus_reg #(.W(DATA_W)) u_z   (.clk(clk), .rst(rst), .ld(ld_en[LD_Z]),
    .d(alu_sum), .q(z_q));
  sbus_reg #(.W(DATA_W)) u_ac  (.clk(clk), .rst(rst), .ld(ld_en[LD_AC]),
    .d(bus), .q(ac_q));
  sbus_reg #(.W(ADDR_W)) u_pc  (.clk(clk), .rst(rst), .ld(ld_en[LD_PC]),
    .d(bus[ADDR_W-1:0]), .q(pc_q));

  always_comb begin
    pc_ext = '0;
    pc_ext[ADDR_W-1:0] = pc_q;
  end

  assign src[SRC_IR]  = ir_q;
  assign src[SRC_MBR] = mbr_q;
  assign src[SRC_AC]  = ac_q;
  assign src[SRC_Z]   = z_q;
  assign src[SRC_PC]  = pc_ext;

  sbus_bus #(.W(DATA_W), .N(NSRC)) u_bus (
    .en(drv_en), .src(src), .bus(bus), .multi(multi)
  );

  sbus_alu #(.W(DATA_W)) u_alu (.opa(y_q), .opb(bus), .sum(alu_sum));

  always_ff @(posedge clk) begin
    if (rst) conflict_q <= 1'b0;
    else     conflict_q <= multi;
  end

  assign mem_addr     = mar_q;
  assign ac_out       = ac_q;
  assign pc_out       = pc_q;
  assign bus_conflict = conflict_q;

  AST_RD_ADDR_FROM_IR: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr == $past(ir_q[ADDR_W-1:0]))); // R3
  AST_AC_FROM_Z: assert property (@(posedge clk) disable iff (rst)
    done |-> (ac_q == $past(z_q))); // R4
  AST_Z_IS_SUM: assert property (@(posedge clk) disable iff (rst)
    (step == ST_T5) |-> (z_q == $past(ac_q) + $past(y_q))); // R8
  AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    !bus_conflict); // R6
  AST_PC_STABLE: assert property (@(posedge clk) disable iff (rst)
    $stable(pc_q)); // R9
endmodule

// File: tb/sbus_acc_ctrl_tb.sv
module sbus_acc_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] instr_in = '0;
  logic [DW-1:0] mem_rdata;
  logic          mem_rd, done, busy, bus_conflict;
  logic [AW-1:0] mem_addr, pc_out;
  logic [DW-1:0] ac_out;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] ac_exp = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    logic [31:0] t;
    t = {20'd0, a} * 32'h0000_9E37;
    return t[DW-1:0] ^ 16'hA55A;
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  sbus_acc_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .instr_in(instr_in),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .done(done), .busy(busy), .ac_out(ac_out), .pc_out(pc_out),
    .bus_conflict(bus_conflict)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one add; if extra_start, a second start with another word at step 3
  task automatic run_op(input logic [DW-1:0] instr, input bit extra_start);
    logic [AW-1:0] a;
    a = instr[AW-1:0];
    ac_exp = ac_exp + mem_f(a);            // R8 wraps
    start = 1'b1; instr_in = instr;
    @(posedge clk); @(negedge clk);
    start = 1'b0; instr_in = $urandom;
    for (int k = 1; k <= 7; k++) begin
      chk(busy == (k <= 6), "R2 busy", busy, k <= 6);
      chk(mem_rd == (k == 2), "R3 mem_rd", mem_rd, k == 2);
      if (k == 2) chk(mem_addr == a, "R3/R7 mem_addr", mem_addr, a);
      chk(done == (k == 6), "R4 done", done, k == 6);
      if (k == 6) chk(ac_out == ac_exp, "R4/R8 ac_out", ac_out, ac_exp);
      chk(bus_conflict == 1'b0, "R6 bus_conflict", bus_conflict, 0);
      if (extra_start && (k == 3 || k == 6)) begin
        start = 1'b1; instr_in = {DW{1'b1}};  // R5 must be ignored
      end else begin
        start = 1'b0;
      end
      @(posedge clk); @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(done == 0 && busy == 0 && mem_rd == 0 && bus_conflict == 0,
        "R1 ctl in reset", {done, busy, mem_rd, bus_conflict}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ac_out == 0, "R1 ac_out", ac_out, 0);
    chk(pc_out == 0, "R1 pc_out", pc_out, 0);
    chk(done == 0 && busy == 0 && mem_rd == 0, "R1 ctl after reset",
        {done, busy, mem_rd}, 0);

    run_op(16'h0000, 0);                    // address 0
    run_op(16'h0FFF, 0);                    // top address
    run_op(16'hF123, 0);                    // R7 upper bits set
    run_op(16'h0123, 1);                    // R5 start while busy
    run_op(16'hA800, 0);
    for (int n = 0; n < 40; n++) begin
      logic [DW-1:0] w;
      w = $urandom;
      run_op(w, ($urandom % 4) == 0);
      if (($urandom % 3) == 0) repeat ($urandom % 3) @(negedge clk);
    end
    chk(ac_out == ac_exp, "R8 final ac_out", ac_out, ac_exp);
    chk(pc_out == 0, "R9 pc_out", pc_out, 0);
    chk(busy == 0, "R2 idle at end", busy, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule